// File: doc/BRIEF.md
# FIFO Bit-Error Tester with Pseudo-Random Halves

This block exercises a 40-bit external FIFO with a stream of pseudo-random test words and checks every word that returns. Each word is built from two independent 20-bit halves. Each half holds 19 bits taken from its own shift-register sequence plus one parity bit. The write side pushes words whenever the FIFO has room. The read side pops whenever the FIFO holds data. The read side rebuilds the expected stream from its own copy of the generators, so the check does not depend on how writes and reads interleave.

A run is started with a one-cycle `start` pulse together with the number of words to move. During the run, every bit position that ever came back wrong is recorded in a sticky mask. Words that contain any wrong bit are counted, and each half keeps its own sticky parity flag. Once the last word has been read, the block reports completion and stays idle until the next `start`.

Top module: `fifo_integrity_tester`

## Requirements
- R1: After reset, `busy`, `done`, `fifo_wr_en`, `fifo_rd_en`, `err_mask`, `err_count` and `par_err` are all zero.
- R2: Each half generator is a 20-bit register s that steps to {s[18:0], s[19]^s[16]}. The upper half is seeded with 20'hA5A5A and the lower half with 20'h3C3C3. A half word is {^s[18:0], s[18:0]}, so bit 39 and bit 19 are even-parity bits over bits 38:20 and 18:0.
- R3: `fifo_wr_en` is high only while a run is active, `fifo_full` is low, `start` is low and fewer than `num_words` words have been written. The write generator advances only on a write that is accepted.
- R4: `fifo_rd_en` is high only while a run is active, `fifo_empty` is low, `start` is low and fewer than `num_words` words have been read. The read generator advances only on a read that is accepted. The word compared is the `fifo_rdata` shown while `fifo_rd_en` is high.
- R5: On every accepted read, `err_mask` is ORed with the XOR of `fifo_rdata` and the expected word. Bits are never cleared except by `start`.
- R6: `err_count` (CNT_W bits) increments by one for each accepted read with any mismatching bit. It holds at all ones instead of wrapping.
- R7: `par_err[1]` / `par_err[0]` become set and stay set when an accepted read has odd parity over bits 39:20 / 19:0.
- R8: A `start` pulse reseeds both generators, clears `err_mask`, `err_count` and `par_err`, loads `num_words`, and can restart a run in progress. No write or read takes place in the `start` cycle.
- R9: `done` rises in the cycle after the read of the last word is accepted. At the same time `busy` falls, and `done` holds until the next `start`. If `num_words` is zero, `done` rises in the cycle after `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new run (one-cycle pulse) |
| num_words | input | LEN_W | Number of words in the run, sampled on `start` |
| fifo_wr_en | output | 1 | Push strobe to the FIFO |
| fifo_wdata | output | 40 | Word pushed to the FIFO |
| fifo_full | input | 1 | FIFO cannot accept a push |
| fifo_rd_en | output | 1 | Pop strobe to the FIFO |
| fifo_rdata | input | 40 | Head word of the FIFO (show-ahead) |
| fifo_empty | input | 1 | FIFO holds no readable word |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last run completed |
| err_mask | output | 40 | Sticky mask of mismatching bit positions |
| err_count | output | CNT_W | Saturating count of words with errors |
| par_err | output | 2 | Sticky parity failure flags, [1] upper half, [0] lower half |

## Verification
The bench stalls the FIFO on both sides in irregular patterns. A design that advanced a generator on a refused request would drift out of step, and every later word would then look corrupt. Single-bit faults must show up as one mask bit and as a parity flag on the correct half. A two-bit fault inside one half must set mask bits but leave parity clean. A long run in which every word is faulty drives the narrowed counter past its ceiling, where a wrapping counter would fall back to a small value. Two further cases are a zero-length run, which must finish at once, and a restart in the middle of a faulty run, which must discard all of the old error state.

// File: rtl/fit_pkg.sv
package fit_pkg;
    localparam int HALF_W = 20;
    localparam int WORD_W = 2 * HALF_W;
    localparam int HALVES = 2;

    localparam logic [HALF_W-1:0] SEED_UPPER = 20'hA5A5A;
    localparam logic [HALF_W-1:0] SEED_LOWER = 20'h3C3C3;

    typedef enum logic [1:0] {
        RUN_IDLE,
        RUN_ACTIVE,
        RUN_FINISHED
    } run_state_e;

    function automatic logic [HALF_W-1:0] half_seed(input int idx);
        return (idx == 1) ? SEED_UPPER : SEED_LOWER;
    endfunction

    // x^20 + x^17 + 1, Fibonacci form
    function automatic logic [HALF_W-1:0] lfsr_step(input logic [HALF_W-1:0] s);
        return {s[HALF_W-2:0], s[HALF_W-1] ^ s[16]};
    endfunction

    // 19 payload bits plus an even-parity bit on top
    function automatic logic [HALF_W-1:0] pack_half(input logic [HALF_W-1:0] s);
        return {^s[HALF_W-2:0], s[HALF_W-2:0]};
    endfunction
endpackage

// File: rtl/fit_lfsr_bank.sv
module fit_lfsr_bank
    import fit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    output logic [WORD_W-1:0] word
);
    for (genvar h = 0; h < HALVES; h++) begin : g_half
        logic [HALF_W-1:0] state_q;

        always_ff @(posedge clk) begin
            if (rst || load) begin
                state_q <= half_seed(h);
            end else if (step) begin
                state_q <= lfsr_step(state_q);
            end
        end

        assign word[h*HALF_W +: HALF_W] = pack_half(state_q);
    end
endmodule

// File: rtl/fit_compare.sv
module fit_compare
    import fit_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              check,
    input  logic [WORD_W-1:0] rdata,
    input  logic [WORD_W-1:0] ref_word,
    output logic [WORD_W-1:0] mask,
    output logic [CNT_W-1:0]  count,
    output logic [HALVES-1:0] par_flag
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [WORD_W-1:0] diff;
    assign diff = rdata ^ ref_word;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            mask  <= '0;
            count <= '0;
        end else if (check) begin
            mask <= mask | diff;
            if (|diff && count != CNT_MAX) begin
                count <= count + 1'b1;
            end
        end
    end

    for (genvar h = 0; h < HALVES; h++) begin : g_par
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                par_flag[h] <= 1'b0;
            end else if (check && ^rdata[h*HALF_W +: HALF_W]) begin
                par_flag[h] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/fifo_integrity_tester.sv
module fifo_integrity_tester
    import fit_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int LEN_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [LEN_W-1:0]  num_words,
    output logic              fifo_wr_en,
    output logic [WORD_W-1:0] fifo_wdata,
    input  logic              fifo_full,
    output logic              fifo_rd_en,
    input  logic [WORD_W-1:0] fifo_rdata,
    input  logic              fifo_empty,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] err_mask,
    output logic [CNT_W-1:0]  err_count,
    output logic [HALVES-1:0] par_err
);
    run_state_e        state_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  wr_cnt_q;
    logic [LEN_W-1:0]  rd_cnt_q;
    logic [WORD_W-1:0] ref_word;
    logic              wr_go;
    logic              rd_go;

    assign busy  = (state_q == RUN_ACTIVE);
    assign done  = (state_q == RUN_FINISHED);
    assign wr_go = busy && !start && (wr_cnt_q != len_q) && !fifo_full;
    assign rd_go = busy && !start && (rd_cnt_q != len_q) && !fifo_empty;

    assign fifo_wr_en = wr_go;
    assign fifo_rd_en = rd_go;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= RUN_IDLE;
            len_q    <= '0;
            wr_cnt_q <= '0;
            rd_cnt_q <= '0;
        end else if (start) begin
            state_q  <= (num_words == '0) ? RUN_FINISHED : RUN_ACTIVE;
            len_q    <= num_words;
            wr_cnt_q <= '0;
            rd_cnt_q <= '0;
        end else begin
            if (wr_go) begin
                wr_cnt_q <= wr_cnt_q + 1'b1;
            end
            if (rd_go) begin
                rd_cnt_q <= rd_cnt_q + 1'b1;
                if (rd_cnt_q == len_q - 1'b1) begin
                    state_q <= RUN_FINISHED;
                end
            end
        end
    end

    fit_lfsr_bank u_wgen (
        .clk  (clk),
        .rst  (rst),
        .load (start),
        .step (wr_go),
        .word (fifo_wdata)
    );

    fit_lfsr_bank u_rgen (
        .clk  (clk),
        .rst  (rst),
        .load (start),
        .step (rd_go),
        .word (ref_word)
    );

    fit_compare #(.CNT_W(CNT_W)) u_cmp (
        .clk      (clk),
        .rst      (rst),
        .clear    (start),
        .check    (rd_go),
        .rdata    (fifo_rdata),
        .ref_word (ref_word),
        .mask     (err_mask),
        .count    (err_count),
        .par_flag (par_err)
    );
endmodule

// File: rtl/fit_sva.sv
module fit_sva #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             fifo_full,
    input logic             fifo_empty,
    input logic             fifo_wr_en,
    input logic             fifo_rd_en,
    input logic             busy,
    input logic             done,
    input logic [39:0]      err_mask,
    input logic [CNT_W-1:0] err_count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    p_wr_guard_r3: assert property (@(posedge clk) disable iff (rst)
        fifo_wr_en |-> (!fifo_full && busy && !start));

    p_rd_guard_r4: assert property (@(posedge clk) disable iff (rst)
        fifo_rd_en |-> (!fifo_empty && busy && !start));

    p_mask_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(start) && !$past(rst)) |-> ((err_mask & $past(err_mask)) == $past(err_mask)));

    p_count_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(start) && !$past(rst) && $past(err_count) == CNT_MAX) |-> (err_count == CNT_MAX));

    p_start_clear_r8: assert property (@(posedge clk) disable iff (rst)
        start |=> (err_mask == '0 && err_count == '0));

    p_done_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !fifo_wr_en && !fifo_rd_en));
endmodule

bind fifo_integrity_tester fit_sva #(.CNT_W(CNT_W)) u_sva (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .fifo_full  (fifo_full),
    .fifo_empty (fifo_empty),
    .fifo_wr_en (fifo_wr_en),
    .fifo_rd_en (fifo_rd_en),
    .busy       (busy),
    .done       (done),
    .err_mask   (err_mask),
    .err_count  (err_count)
);

// File: tb/fifo_integrity_tester_test.sv
`timescale 1ns/1ps
module fifo_integrity_tester_test;
    localparam int CW    = 4;
    localparam int DEPTH = 4;
    localparam logic [CW-1:0] CMAX = '1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [31:0] num_words = '0;
    logic fifo_wr_en, fifo_rd_en, fifo_full, fifo_empty, busy, done;
    logic [39:0] fifo_wdata, fifo_rdata, err_mask;
    logic [CW-1:0] err_count;
    logic [1:0] par_err;

    always #2.5 clk = ~clk;

    fifo_integrity_tester #(.CNT_W(CW), .LEN_W(32)) uut (
        .clk(clk), .rst(rst), .start(start), .num_words(num_words),
        .fifo_wr_en(fifo_wr_en), .fifo_wdata(fifo_wdata), .fifo_full(fifo_full),
        .fifo_rd_en(fifo_rd_en), .fifo_rdata(fifo_rdata), .fifo_empty(fifo_empty),
        .busy(busy), .done(done), .err_mask(err_mask), .err_count(err_count),
        .par_err(par_err)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural FIFO with fault injection ----------------
    logic [39:0] q[$];
    int          qn = 0;
    logic [39:0] head = '0;
    int          pops = 0;
    logic        wr_block = 1'b0, rd_block = 1'b0;
    int          fault_at = -1;
    logic        fault_all = 1'b0;
    logic [39:0] fault_xor = '0;

    always @(posedge clk) begin
        if (start) begin
            q.delete();
            pops <= 0;
        end else begin
            if (fifo_rd_en && q.size() > 0) begin
                void'(q.pop_front());
                pops <= pops + 1;
            end
            if (fifo_wr_en) q.push_back(fifo_wdata);
        end
        qn   <= q.size();
        head <= (q.size() > 0) ? q[0] : '0;
    end

    assign fifo_full  = (qn >= DEPTH) || wr_block;
    assign fifo_empty = (qn == 0) || rd_block;
    assign fifo_rdata = head ^ ((fault_all || pops == fault_at) ? fault_xor : 40'h0);

    // ---------------- reference model ----------------
    function automatic logic [19:0] m_step(input logic [19:0] s);
        return {s[18:0], s[19] ^ s[16]};
    endfunction
    function automatic logic [39:0] m_word(input logic [19:0] hi, input logic [19:0] lo);
        return {^hi[18:0], hi[18:0], ^lo[18:0], lo[18:0]};
    endfunction

    logic [19:0] mw_hi, mw_lo, mr_hi, mr_lo;
    int          m_n, m_wc, m_rc;
    logic        m_busy, m_done;
    logic [39:0] m_mask;
    logic [CW-1:0] m_cnt;
    logic [1:0]  m_par;

    always @(negedge clk) begin
        logic ew, er;
        logic [39:0] d;
        if (rst) begin
            mw_hi = 20'hA5A5A; mw_lo = 20'h3C3C3; mr_hi = 20'hA5A5A; mr_lo = 20'h3C3C3;
            m_n = 0; m_wc = 0; m_rc = 0; m_busy = 0; m_done = 0;
            m_mask = '0; m_cnt = '0; m_par = '0;
        end else begin
            ew = m_busy && !start && m_wc < m_n && !fifo_full;
            er = m_busy && !start && m_rc < m_n && !fifo_empty;
            chk("R3 wr_en", fifo_wr_en, ew);
            if (ew) chk("R2 wdata", fifo_wdata, m_word(mw_hi, mw_lo));
            chk("R4 rd_en", fifo_rd_en, er);
            chk("R9 busy", busy, m_busy);
            chk("R9 done", done, m_done);
            chk("R5 mask", err_mask, m_mask);
            chk("R6 count", err_count, m_cnt);
            chk("R7 par", par_err, m_par);
            if (start) begin
                mw_hi = 20'hA5A5A; mw_lo = 20'h3C3C3; mr_hi = 20'hA5A5A; mr_lo = 20'h3C3C3;
                m_n = int'(num_words); m_wc = 0; m_rc = 0;
                m_busy = (num_words != 0); m_done = (num_words == 0);
                m_mask = '0; m_cnt = '0; m_par = '0;
            end else begin
                if (ew) begin
                    mw_hi = m_step(mw_hi); mw_lo = m_step(mw_lo); m_wc++;
                end
                if (er) begin
                    d = fifo_rdata ^ m_word(mr_hi, mr_lo);
                    m_mask |= d;
                    if (d != 0 && m_cnt != CMAX) m_cnt++;
                    if (^fifo_rdata[39:20]) m_par[1] = 1'b1;
                    if (^fifo_rdata[19:0])  m_par[0] = 1'b1;
                    mr_hi = m_step(mr_hi); mr_lo = m_step(mr_lo); m_rc++;
                    if (m_rc == m_n) begin m_busy = 0; m_done = 1; end
                end
            end
        end
    end

    // ---------------- flow-control pattern ----------------
    logic flow_on = 1'b0;
    int   cyc = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1;
        if (flow_on) begin
            wr_block = (cyc % 5) == 0;
            rd_block = (cyc % 11) < 6;
        end else begin
            wr_block = 1'b0;
            rd_block = 1'b0;
        end
    end

    task automatic kick(input int n);
        @(posedge clk); #1;
        start = 1'b1; num_words = n;
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    task automatic finish_run();
        @(negedge clk);
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 wr_en", fifo_wr_en, 0);
        chk("R1 rd_en", fifo_rd_en, 0);
        chk("R1 mask", err_mask, 0);
        chk("R1 count", err_count, 0);
        chk("R1 par", par_err, 0);

        // clean run, no stalls
        kick(50); finish_run();
        chk("R5 clean mask", err_mask, 0);
        chk("R9 clean done", done, 1);

        // clean run with stalls on both sides
        flow_on = 1'b1;
        kick(300); finish_run();
        chk("R3 R4 stalled mask", err_mask, 0);
        chk("R6 stalled count", err_count, 0);
        flow_on = 1'b0;

        // single-bit fault in upper half, bit 21, on word 5
        fault_at = 5; fault_xor = 40'h0_0020_0000;
        flow_on = 1'b1;
        kick(40); finish_run();
        flow_on = 1'b0;
        chk("R5 single mask", err_mask, 40'h0_0020_0000);
        chk("R6 single count", err_count, 1);
        chk("R7 single par", par_err, 2'b10);

        // two-bit fault in lower half: parity stays good
        fault_at = 7; fault_xor = 40'h18;
        kick(20); finish_run();
        chk("R5 double mask", err_mask, 40'h18);
        chk("R6 double count", err_count, 1);
        chk("R7 double par", par_err, 2'b00);

        // every word faulty: counter saturates
        fault_at = -1; fault_all = 1'b1; fault_xor = 40'h1;
        kick(40); finish_run();
        chk("R6 saturate", err_count, CMAX);
        chk("R7 lower par", par_err, 2'b01);

        // zero-length run
        fault_all = 1'b0; fault_xor = '0;
        kick(0);
        @(negedge clk);
        chk("R9 zero done", done, 1);
        chk("R8 zero cleared", err_count, 0);

        // restart mid-run discards error state
        fault_all = 1'b1; fault_xor = 40'h80_0000_0000;
        kick(200);
        repeat (30) @(posedge clk);
        #1 fault_all = 1'b0; fault_xor = '0;
        kick(25); finish_run();
        chk("R8 restart mask", err_mask, 0);
        chk("R8 restart count", err_count, 0);
        chk("R8 restart par", par_err, 0);

        summary();
    end
endmodule